// File: doc/BRIEF.md
# Dual-Port Mailbox and Doorbell Register Block

This block is a small memory-mapped register file that lets a host and a remote controller exchange fixed-size messages. Each side has its own simple register port: a request strobe, a write flag, an address and write data. Read data and an error flag come back one clock after the strobe. Eight 64-bit mailbox words form the message area. The host owns the four request words and fills them. The remote side owns the four response words and fills them. Both sides may read all eight words.

Two 64-bit doorbell registers carry the notifications. The outbound doorbell signals from host to remote, and the inbound doorbell signals from remote to host. Each doorbell appears at three adjacent offsets: a plain read/write offset, an offset whose write data is ANDed into the register, and an offset whose write data is ORed into it. Either side can therefore set or clear one bit without a read-modify-write sequence. The top bit of each doorbell drives an interrupt line straight to the side that must react.

A typical exchange runs as follows. The host fills the request words and ORs bit 63 into the outbound doorbell, which raises the remote interrupt. The remote side clears that bit, writes the response words and ORs bit 63 into the inbound doorbell. The host reads the response and clears the inbound bit with an AND mask of 0x7FFF_FFFF_FFFF_FFFF.

Top module: `mbox_doorbell_regs`

## Requirements
- R1: After reset, every mailbox word and both doorbells read as zero, both interrupt outputs are low and neither error output is set.
- R2: A host write to offsets 0x50 to 0x53 stores the request word, and either port reads it back at that offset. Read data and the error flag appear in the clock after the request strobe.
- R3: A remote write to offsets 0x54 to 0x57 stores the response word, and either port reads it back.
- R4: A host write to 0x54 to 0x57, or a remote write to 0x50 to 0x53, leaves the word unchanged and sets that port's error flag for one cycle.
- R5: The outbound doorbell is at 0x60 for plain read/write, at 0x61 where the stored value becomes old AND data, and at 0x62 where the stored value becomes old OR data.
- R6: The inbound doorbell has the same three access forms at 0x63 (plain), 0x64 (AND) and 0x65 (OR).
- R7: irq_remote equals bit 63 of the outbound doorbell and irq_host equals bit 63 of the inbound doorbell. Each follows its register in the cycle after the write.
- R8: A read of an AND or OR offset returns the current doorbell value and leaves the doorbell unchanged.
- R9: When both ports write the same doorbell in one cycle, the new value is formed in this order. All AND masks are applied to the old value first, then all OR masks. A plain write then replaces the result, and if both ports do a plain write the remote port's data wins.
- R10: An access to any offset outside 0x50 to 0x57 and 0x60 to 0x65 returns zero read data and sets the error flag for one cycle. A write to such an offset changes no register.
- R11: An access to a mapped offset that the port may use leaves the error flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | Host access is a write when high |
| h_addr | input | ADDR_W | Host register offset |
| h_wdata | input | DATA_W | Host write data or mask |
| h_rdata | output | DATA_W | Host read data, valid the cycle after the strobe |
| h_err | output | 1 | Host access error, pulses the cycle after the strobe |
| r_req | input | 1 | Remote access strobe |
| r_wr | input | 1 | Remote access is a write when high |
| r_addr | input | ADDR_W | Remote register offset |
| r_wdata | input | DATA_W | Remote write data or mask |
| r_rdata | output | DATA_W | Remote read data, valid the cycle after the strobe |
| r_err | output | 1 | Remote access error, pulses the cycle after the strobe |
| irq_host | output | 1 | Response-waiting interrupt (inbound doorbell bit 63) |
| irq_remote | output | 1 | Message-available interrupt (outbound doorbell bit 63) |

## Verification
A corrupted doorbell bit 63 shows on the interrupt outputs in the very next cycle, with no access needed. Any other corrupted doorbell bit or mailbox word stays hidden until a port reads that offset, and then it appears in the read data one clock after the strobe. A decode fault shows one clock after the strobe, either as a wrong error pulse or as a register that changed from a write it should have ignored. For that reason the tests read back neighbouring registers after every ownership or unmapped write. They also drive both ports in the same cycle to expose a merge order that does not follow R9.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int OFF_W      = 8;
  localparam int MBOX_WORDS = 8;
  localparam int MBOX_OFF   = 'h50;
  localparam int DBELL_CNT  = 2;
  localparam int ALIAS_CNT  = 3;
  localparam int DBELL_OFF  = 'h60;
  localparam int MIDX_W     = $clog2(MBOX_WORDS);
  localparam int DIDX_W     = (DBELL_CNT > 1) ? $clog2(DBELL_CNT) : 1;

  typedef enum logic [1:0] {SEL_NONE, SEL_MBOX, SEL_DBELL} sel_e;
  typedef enum logic [1:0] {DOP_RW, DOP_AND, DOP_OR} dop_e;

  typedef struct packed {
    sel_e              sel;
    logic [MIDX_W-1:0] mbox_idx;
    logic [DIDX_W-1:0] dbell_idx;
    dop_e              op;
  } dec_t;

  // Offset decode: mailbox words first, then doorbells with three aliases each
  function automatic dec_t decode_offset(input logic [OFF_W-1:0] off);
    dec_t d;
    int   o;
    int   rel;
    o           = int'(off);
    d.sel       = SEL_NONE;
    d.mbox_idx  = '0;
    d.dbell_idx = '0;
    d.op        = DOP_RW;
    if (o >= MBOX_OFF && o < MBOX_OFF + MBOX_WORDS) begin
      d.sel      = SEL_MBOX;
      d.mbox_idx = MIDX_W'(o - MBOX_OFF);
    end else if (o >= DBELL_OFF && o < DBELL_OFF + DBELL_CNT * ALIAS_CNT) begin
      rel         = o - DBELL_OFF;
      d.sel       = SEL_DBELL;
      d.dbell_idx = DIDX_W'(rel / ALIAS_CNT);
      d.op        = dop_e'(2'(rel % ALIAS_CNT));
    end
    return d;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int OWN_LO  = 0,
  parameter int OWN_CNT = 4
) (
  input  logic                  req,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  output dec_t                  dec,
  output logic [MBOX_WORDS-1:0] mbox_we,
  output logic [DBELL_CNT-1:0]  and_we,
  output logic [DBELL_CNT-1:0]  or_we,
  output logic [DBELL_CNT-1:0]  plain_we,
  output logic                  err
);
  logic in_range;
  logic owned;

  assign in_range = ((addr >> OFF_W) == '0);

  always_comb begin
    dec = decode_offset(addr[OFF_W-1:0]);
    if (!in_range) dec.sel = SEL_NONE;
  end

  assign owned = (int'(dec.mbox_idx) >= OWN_LO) &&
                 (int'(dec.mbox_idx) < OWN_LO + OWN_CNT);

  always_comb begin
    mbox_we  = '0;
    and_we   = '0;
    or_we    = '0;
    plain_we = '0;
    if (req && wr) begin
      if (dec.sel == SEL_MBOX && owned) mbox_we[dec.mbox_idx] = 1'b1;
      if (dec.sel == SEL_DBELL) begin
        case (dec.op)
          DOP_AND: and_we[dec.dbell_idx]   = 1'b1;
          DOP_OR:  or_we[dec.dbell_idx]    = 1'b1;
          default: plain_we[dec.dbell_idx] = 1'b1;
        endcase
      end
    end
  end

  assign err = req && ((dec.sel == SEL_NONE) ||
                       (wr && dec.sel == SEL_MBOX && !owned));
endmodule

// File: rtl/mbx_mailbox_bank.sv
module mbx_mailbox_bank
  import mbx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NPORT  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NPORT-1:0][MBOX_WORDS-1:0]       we,
  input  logic [NPORT-1:0][DATA_W-1:0]           wdata,
  output logic [MBOX_WORDS-1:0][DATA_W-1:0]      words
);
  localparam int PER_PORT = MBOX_WORDS / NPORT;

  function automatic int owner_of(input int w);
    return w / PER_PORT;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      words <= '0;
    end else begin
      for (int w = 0; w < MBOX_WORDS; w++) begin
        if (we[owner_of(w)][w]) words[w] <= wdata[owner_of(w)];
      end
    end
  end

  generate
    for (genvar w = 0; w < MBOX_WORDS; w++) begin : g_chk
      localparam int OWNER = w / PER_PORT;
      // R4: a word only changes after a write from its owning port
      assert_word_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(words[w]) |-> $past(we[OWNER][w]));
      // R2 R3: an owner write stores exactly that port's data
      assert_word_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we[OWNER][w]) |-> (words[w] == $past(wdata[OWNER])));
    end
  endgenerate
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell #(
  parameter int DATA_W = 64,
  parameter int NPORT  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             and_we,
  input  logic [NPORT-1:0]             or_we,
  input  logic [NPORT-1:0]             plain_we,
  input  logic [NPORT-1:0][DATA_W-1:0] wdata,
  output logic [DATA_W-1:0]            value,
  output logic                         flag
);
  logic [DATA_W-1:0] and_mask;
  logic [DATA_W-1:0] or_mask;
  logic              any_and;
  logic              any_or;
  logic              any_plain;
  logic [DATA_W-1:0] next_value;

  // AND masks first, then OR masks; plain writes override, highest port last
  function automatic logic [DATA_W-1:0] merge_value(
    input logic [DATA_W-1:0]            old,
    input logic [NPORT-1:0]             a_we,
    input logic [NPORT-1:0]             o_we,
    input logic [NPORT-1:0]             p_we,
    input logic [NPORT-1:0][DATA_W-1:0] d
  );
    logic [DATA_W-1:0] v;
    v = old;
    for (int p = 0; p < NPORT; p++) if (a_we[p]) v = v & d[p];
    for (int p = 0; p < NPORT; p++) if (o_we[p]) v = v | d[p];
    for (int p = 0; p < NPORT; p++) if (p_we[p]) v = d[p];
    return v;
  endfunction

  always_comb begin
    and_mask = '1;
    or_mask  = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (and_we[p]) and_mask = and_mask & wdata[p];
      if (or_we[p])  or_mask  = or_mask | wdata[p];
    end
  end

  assign any_and    = |and_we;
  assign any_or     = |or_we;
  assign any_plain  = |plain_we;
  assign next_value = merge_value(value, and_we, or_we, plain_we, wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= next_value;
  end

  assign flag = value[DATA_W-1];

  // R8: with no write of any form the doorbell holds
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_and || any_or || any_plain) |-> $stable(value));
  // R5: OR-only updates leave every mask bit set
  assert_or_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(any_or && !any_plain) |-> ((value & $past(or_mask)) == $past(or_mask)));
  // R6: AND-only updates leave no bit outside the mask
  assert_and_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(any_and && !any_or && !any_plain) |-> ((value & ~$past(and_mask)) == '0));
  // R9: the highest port's plain write wins
  assert_plain_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(plain_we[NPORT-1]) |-> (value == $past(wdata[NPORT-1])));
endmodule

// File: rtl/mbox_doorbell_regs.sv
module mbox_doorbell_regs
  import mbx_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_req,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_err,
  input  logic              r_req,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_err,
  output logic              irq_host,
  output logic              irq_remote
);
  localparam int NPORT    = 2;
  localparam int PER_PORT = MBOX_WORDS / NPORT;
  localparam int DB_OUT   = 0;
  localparam int DB_IN    = 1;

  logic [NPORT-1:0]                  req_a;
  logic [NPORT-1:0]                  wr_a;
  logic [NPORT-1:0][ADDR_W-1:0]      addr_a;
  logic [NPORT-1:0][DATA_W-1:0]      wdata_a;
  dec_t [NPORT-1:0]                  dec_a;
  logic [NPORT-1:0][MBOX_WORDS-1:0]  mbox_we;
  logic [NPORT-1:0][DBELL_CNT-1:0]   db_and;
  logic [NPORT-1:0][DBELL_CNT-1:0]   db_or;
  logic [NPORT-1:0][DBELL_CNT-1:0]   db_plain;
  logic [NPORT-1:0]                  err_now;
  logic [NPORT-1:0][DATA_W-1:0]      rd_now;
  logic [NPORT-1:0][DATA_W-1:0]      rdata_q;
  logic [NPORT-1:0]                  err_q;
  logic [MBOX_WORDS-1:0][DATA_W-1:0] mbox_q;
  logic [DBELL_CNT-1:0][DATA_W-1:0]  db_q;
  logic [DBELL_CNT-1:0]              db_flag;
  logic                              in_db_touched;
  logic                              out_db_touched;

  // Port 0 is the host, port 1 the remote side
  assign req_a   = {r_req, h_req};
  assign wr_a    = {r_wr, h_wr};
  assign addr_a  = {r_addr, h_addr};
  assign wdata_a = {r_wdata, h_wdata};

  function automatic logic [DATA_W-1:0] read_pick(
    input dec_t                              d,
    input logic [MBOX_WORDS-1:0][DATA_W-1:0] mb,
    input logic [DBELL_CNT-1:0][DATA_W-1:0]  db
  );
    case (d.sel)
      SEL_MBOX:  return mb[d.mbox_idx];
      SEL_DBELL: return db[d.dbell_idx];
      default:   return '0;
    endcase
  endfunction

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      mbx_port_decode #(
        .ADDR_W (ADDR_W),
        .OWN_LO (p * PER_PORT),
        .OWN_CNT(PER_PORT)
      ) u_dec (
        .req     (req_a[p]),
        .wr      (wr_a[p]),
        .addr    (addr_a[p]),
        .dec     (dec_a[p]),
        .mbox_we (mbox_we[p]),
        .and_we  (db_and[p]),
        .or_we   (db_or[p]),
        .plain_we(db_plain[p]),
        .err     (err_now[p])
      );
      assign rd_now[p] = read_pick(dec_a[p], mbox_q, db_q);
    end

    for (genvar b = 0; b < DBELL_CNT; b++) begin : g_dbell
      mbx_doorbell #(
        .DATA_W(DATA_W),
        .NPORT (NPORT)
      ) u_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .and_we  ({db_and[1][b], db_and[0][b]}),
        .or_we   ({db_or[1][b], db_or[0][b]}),
        .plain_we({db_plain[1][b], db_plain[0][b]}),
        .wdata   (wdata_a),
        .value   (db_q[b]),
        .flag    (db_flag[b])
      );
    end
  endgenerate

  mbx_mailbox_bank #(
    .DATA_W(DATA_W),
    .NPORT (NPORT)
  ) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mbox_we),
    .wdata(wdata_a),
    .words(mbox_q)
  );

  // Registered read path: data and error valid the cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        err_q[p] <= err_now[p];
        if (req_a[p]) rdata_q[p] <= rd_now[p];
      end
    end
  end

  assign h_rdata    = rdata_q[0];
  assign r_rdata    = rdata_q[1];
  assign h_err      = err_q[0];
  assign r_err      = err_q[1];
  assign irq_remote = db_flag[DB_OUT];
  assign irq_host   = db_flag[DB_IN];

  assign in_db_touched  = db_or[0][DB_IN]  | db_or[1][DB_IN]  |
                          db_plain[0][DB_IN]  | db_plain[1][DB_IN];
  assign out_db_touched = db_or[0][DB_OUT] | db_or[1][DB_OUT] |
                          db_plain[0][DB_OUT] | db_plain[1][DB_OUT];

  // R10: unmapped access returns zero with error
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(h_req && dec_a[0].sel == SEL_NONE) |-> (h_err && h_rdata == '0));
  // R11: mapped reads never flag an error
  assert_mapped_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(r_req && !r_wr && dec_a[1].sel != SEL_NONE) |-> !r_err);
  // R7: interrupts rise only after a setting write to their doorbell
  assert_irq_host_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_host) |-> $past(in_db_touched));
  assert_irq_remote_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_remote) |-> $past(out_db_touched));
endmodule

// File: tb/mbox_doorbell_regs_tb_top.sv
module mbox_doorbell_regs_tb_top;
  localparam logic [63:0] TOP_BIT = 64'h8000_0000_0000_0000;
  localparam logic [63:0] CLR_TOP = 64'h7FFF_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_addr = '0;
  logic [63:0] h_wdata = '0;
  logic [63:0] h_rdata;
  logic        h_err;
  logic        r_req = 1'b0, r_wr = 1'b0;
  logic [7:0]  r_addr = '0;
  logic [63:0] r_wdata = '0;
  logic [63:0] r_rdata;
  logic        r_err;
  logic        irq_host, irq_remote;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  mbox_doorbell_regs dut_i (
    .clk(clk), .rst_n(rst_n),
    .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_err(h_err),
    .r_req(r_req), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_err(r_err),
    .irq_host(irq_host), .irq_remote(irq_remote)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic [7:0] a, input logic [63:0] d,
                         output logic [63:0] rd, output logic e);
    @(negedge clk);
    h_req = 1'b1; h_wr = wr; h_addr = a; h_wdata = d;
    @(negedge clk);
    h_req = 1'b0; h_wr = 1'b0;
    rd = h_rdata; e = h_err;
  endtask

  task automatic rem_op(input logic wr, input logic [7:0] a, input logic [63:0] d,
                        output logic [63:0] rd, output logic e);
    @(negedge clk);
    r_req = 1'b1; r_wr = wr; r_addr = a; r_wdata = d;
    @(negedge clk);
    r_req = 1'b0; r_wr = 1'b0;
    rd = r_rdata; e = r_err;
  endtask

  task automatic both_write(input logic [7:0] ha, input logic [63:0] hd,
                            input logic [7:0] ra, input logic [63:0] rdd);
    @(negedge clk);
    h_req = 1'b1; h_wr = 1'b1; h_addr = ha; h_wdata = hd;
    r_req = 1'b1; r_wr = 1'b1; r_addr = ra; r_wdata = rdd;
    @(negedge clk);
    h_req = 1'b0; h_wr = 1'b0; r_req = 1'b0; r_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] rd; logic e;
    chk(irq_host == 1'b0 && irq_remote == 1'b0, "R1 irqs low", {62'd0, irq_host, irq_remote}, 64'd0);
    host_op(1'b0, 8'h50, '0, rd, e);
    chk(rd == 64'd0 && !e, "R1 request word zero", rd, 64'd0);
    rem_op(1'b0, 8'h57, '0, rd, e);
    chk(rd == 64'd0 && !e, "R1 response word zero", rd, 64'd0);
    host_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == 64'd0 && !e, "R1 inbound doorbell zero", rd, 64'd0);
  endtask

  task automatic t_request_words();
    logic [63:0] rd; logic e;
    for (int i = 0; i < 4; i++) begin
      host_op(1'b1, 8'(8'h50 + i), 64'hA5A5_0000_0000_1000 + 64'(i), rd, e);
      chk(!e, "R11 host request write no error", {63'd0, e}, 64'd0);
    end
    for (int i = 0; i < 4; i++) begin
      rem_op(1'b0, 8'(8'h50 + i), '0, rd, e);
      chk(rd == 64'hA5A5_0000_0000_1000 + 64'(i), "R2 remote reads request word", rd,
          64'hA5A5_0000_0000_1000 + 64'(i));
    end
    host_op(1'b0, 8'h52, '0, rd, e);
    chk(rd == 64'hA5A5_0000_0000_1002, "R2 host reads own request word", rd, 64'hA5A5_0000_0000_1002);
  endtask

  task automatic t_response_words();
    logic [63:0] rd; logic e;
    for (int i = 0; i < 4; i++) rem_op(1'b1, 8'(8'h54 + i), 64'h3C00_0000_0000_0000 | 64'(i * 7), rd, e);
    for (int i = 0; i < 4; i++) begin
      host_op(1'b0, 8'(8'h54 + i), '0, rd, e);
      chk(rd == (64'h3C00_0000_0000_0000 | 64'(i * 7)), "R3 host reads response word", rd,
          64'h3C00_0000_0000_0000 | 64'(i * 7));
    end
  endtask

  task automatic t_ownership();
    logic [63:0] rd; logic e;
    host_op(1'b1, 8'h55, 64'hDEAD_BEEF, rd, e);
    chk(e == 1'b1, "R4 host write to response word flags error", {63'd0, e}, 64'd1);
    rem_op(1'b0, 8'h55, '0, rd, e);
    chk(rd == 64'h3C00_0000_0000_0007, "R4 response word unchanged", rd, 64'h3C00_0000_0000_0007);
    rem_op(1'b1, 8'h51, 64'hBAD0, rd, e);
    chk(e == 1'b1, "R4 remote write to request word flags error", {63'd0, e}, 64'd1);
    host_op(1'b0, 8'h51, '0, rd, e);
    chk(rd == 64'hA5A5_0000_0000_1001 && !e, "R4 request word unchanged", rd, 64'hA5A5_0000_0000_1001);
  endtask

  task automatic t_outbound();
    logic [63:0] rd; logic e;
    host_op(1'b1, 8'h60, 64'h0000_0000_0000_00FF, rd, e);
    chk(irq_remote == 1'b0, "R7 irq_remote low with bit 63 clear", {63'd0, irq_remote}, 64'd0);
    host_op(1'b1, 8'h62, TOP_BIT, rd, e);
    chk(irq_remote == 1'b1, "R7 irq_remote follows bit 63", {63'd0, irq_remote}, 64'd1);
    rem_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == (TOP_BIT | 64'hFF), "R5 OR alias sets bit 63 only", rd, TOP_BIT | 64'hFF);
    rem_op(1'b1, 8'h61, CLR_TOP, rd, e);
    chk(irq_remote == 1'b0, "R7 irq_remote clears", {63'd0, irq_remote}, 64'd0);
    host_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == 64'hFF, "R5 AND alias clears bit 63 only", rd, 64'hFF);
    chk(irq_host == 1'b0, "R7 irq_host unaffected by outbound", {63'd0, irq_host}, 64'd0);
  endtask

  task automatic t_inbound();
    logic [63:0] rd; logic e;
    rem_op(1'b1, 8'h65, TOP_BIT | 64'h3, rd, e);
    chk(irq_host == 1'b1, "R7 irq_host follows inbound bit 63", {63'd0, irq_host}, 64'd1);
    host_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == (TOP_BIT | 64'h3), "R6 inbound OR alias", rd, TOP_BIT | 64'h3);
    host_op(1'b1, 8'h64, CLR_TOP, rd, e);
    chk(irq_host == 1'b0, "R7 irq_host clears", {63'd0, irq_host}, 64'd0);
    rem_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == 64'h3, "R6 inbound AND alias", rd, 64'h3);
    rem_op(1'b1, 8'h63, 64'h1234, rd, e);
    host_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == 64'h1234, "R6 inbound plain write", rd, 64'h1234);
  endtask

  task automatic t_alias_read();
    logic [63:0] rd; logic e;
    host_op(1'b0, 8'h61, '0, rd, e);
    chk(rd == 64'hFF && !e, "R8 AND alias read returns value", rd, 64'hFF);
    rem_op(1'b0, 8'h62, '0, rd, e);
    chk(rd == 64'hFF, "R8 OR alias read returns value", rd, 64'hFF);
    rem_op(1'b0, 8'h64, '0, rd, e);
    chk(rd == 64'h1234, "R8 inbound AND alias read", rd, 64'h1234);
    host_op(1'b0, 8'h65, '0, rd, e);
    chk(rd == 64'h1234, "R8 inbound OR alias read", rd, 64'h1234);
    host_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == 64'hFF, "R8 outbound unchanged by alias reads", rd, 64'hFF);
    host_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == 64'h1234, "R8 inbound unchanged by alias reads", rd, 64'h1234);
  endtask

  task automatic t_combine();
    logic [63:0] rd; logic e;
    host_op(1'b1, 8'h60, 64'hF0F0, rd, e);
    both_write(8'h61, 64'h00FF, 8'h62, 64'h0100);
    host_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == ((64'hF0F0 & 64'h00FF) | 64'h0100), "R9 AND before OR", rd, (64'hF0F0 & 64'h00FF) | 64'h0100);
    both_write(8'h62, 64'h000F, 8'h61, 64'h0000);
    host_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == 64'h000F, "R9 OR after AND across ports", rd, 64'h000F);
    both_write(8'h60, 64'h1111, 8'h61, 64'h0);
    rem_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == 64'h1111, "R9 plain overrides AND", rd, 64'h1111);
    both_write(8'h60, 64'hAAAA, 8'h60, 64'h5555);
    host_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == 64'h5555, "R9 remote plain wins", rd, 64'h5555);
    both_write(8'h61, 64'hFF00, 8'h61, 64'h0F0F);
    host_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == (64'h5555 & 64'hFF00 & 64'h0F0F), "R9 both AND masks", rd, 64'h5555 & 64'hFF00 & 64'h0F0F);
    both_write(8'h65, TOP_BIT, 8'h64, 64'h0);
    chk(irq_host == 1'b1, "R9 inbound AND then OR sets bit 63", {63'd0, irq_host}, 64'd1);
    host_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == TOP_BIT, "R9 inbound combine value", rd, TOP_BIT);
  endtask

  task automatic t_unmapped();
    logic [63:0] rd; logic e;
    host_op(1'b1, 8'h58, '1, rd, e);
    chk(e == 1'b1 && rd == 64'd0, "R10 unmapped write error and zero", rd, 64'd0);
    host_op(1'b0, 8'h66, '0, rd, e);
    chk(e == 1'b1 && rd == 64'd0, "R10 unmapped read 0x66", rd, 64'd0);
    rem_op(1'b1, 8'h00, '1, rd, e);
    chk(e == 1'b1 && rd == 64'd0, "R10 remote unmapped 0x00", rd, 64'd0);
    rem_op(1'b0, 8'h5F, '0, rd, e);
    chk(e == 1'b1, "R10 remote unmapped 0x5F", {63'd0, e}, 64'd1);
    host_op(1'b0, 8'h50, '0, rd, e);
    chk(rd == 64'hA5A5_0000_0000_1000 && !e, "R10 request word untouched", rd, 64'hA5A5_0000_0000_1000);
    rem_op(1'b0, 8'h60, '0, rd, e);
    chk(rd == 64'h0500, "R10 outbound untouched", rd, 64'h0500);
    host_op(1'b0, 8'h63, '0, rd, e);
    chk(rd == TOP_BIT && irq_host && !irq_remote, "R10 inbound and irqs untouched", rd, TOP_BIT);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_request_words();
    t_response_words();
    t_ownership();
    t_outbound();
    t_inbound();
    t_alias_read();
    t_combine();
    t_unmapped();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule